// File: doc/BRIEF.md
# Two-Block Flash Record Logger

This block appends fixed-size records to a log kept in two equal erasable flash blocks. Bytes arrive on a valid/ready stream. Once a full record has been gathered, the block writes it one byte at a time at a write pointer that only moves forward. When one block is full, the pointer moves to offset zero of the other block. A block is erased only when the pointer comes back around to it, so the two blocks share the erases evenly. No byte address is ever programmed a second time between erases.

The block drives a small flash command port and waits for a completion pulse after every command. After each program or erase it reads the status, and it checks the error bit before going on. A failed erase is followed by a clear-status command and then a new erase. This repeats up to a configurable number of attempts. Each block keeps a count of its completed erases. The block stops, and raises a fault flag that holds until reset, in three cases:
- the erase attempts run out;
- a block's erase count has reached its limit when that block needs an erase;
- a byte program reports an error.

Top module: `rec_log_appender`

## Requirements
- R1: After reset, `in_ready` is 1, `fault` is 0 and no command is issued. The write pointer is at offset 0 of block 0, and both blocks are treated as erased.
- R2: No flash command is issued until all REC_BYTES bytes of a record have been accepted. The record's bytes are then programmed in arrival order at consecutive offsets. Each program (`fl_cmd`=1) is followed by a read-status (`fl_cmd`=4) before the next command. `fl_addr` is {block bit as MSB, byte offset}.
- R3: Every command is a one-cycle pulse on `fl_cmd_valid`. `in_ready` stays 0 from the last byte of a record until that record's final `fl_done`.
- R4: When a block is full, the next record is programmed at offset 0 of the other block. The first visit to each block after reset needs no erase.
- R5: When the pointer returns to offset 0 of a block that was written since its last erase, an erase (`fl_cmd`=2, address offset 0) and a read-status come before the first program.
- R6: No byte address is programmed twice without an erase of its block in between.
- R7: When the read-status after an erase reports an error, a clear-status (`fl_cmd`=3) is issued and then the erase again. This continues for up to MAX_TRIES attempts, and MAX_TRIES is at least 3.
- R8: If the last allowed erase attempt also fails, `fault` is raised, and no further command is issued.
- R9: A block's erase count rises by one per successful erase. If a needed erase finds the count at ERASE_LIMIT, `fault` is raised and no erase is issued.
- R10: A read-status error after a byte program raises `fault` immediately.
- R11: `fault` holds until reset, and while it is set `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Record byte valid |
| in_data | input | 8 | Record byte |
| in_ready | output | 1 | Block takes a byte this cycle |
| fl_cmd_valid | output | 1 | One-cycle command strobe |
| fl_cmd | output | 3 | 1 program, 2 erase, 3 clear status, 4 read status |
| fl_addr | output | $clog2(BLK_BYTES)+1 | Block bit and byte offset |
| fl_wdata | output | 8 | Byte to program |
| fl_done | input | 1 | Command completion pulse |
| fl_err | input | 1 | Status error bit, valid with `fl_done` of a read-status |
| fault | output | 1 | Sticky stop flag |

## Verification
The erase limit is the hardest state to reach from the ports. Reaching it takes many full passes over both blocks, and by then the retry path must also have been used. The bench therefore shrinks the blocks to four records and the limit to two erases. It streams records until both blocks have been erased twice, with two failed attempts injected into the first erase. The next wrap must then end in a fault with no erase issued. A separate run makes the attempts run out, and another fails a byte program.

// File: rtl/rec_log_appender.sv
module rec_log_appender #(
  parameter int BLK_BYTES   = 2048,
  parameter int REC_BYTES   = 16,
  parameter int ERASE_LIMIT = 100,
  parameter int MAX_TRIES   = 4,
  localparam int OFF_W = $clog2(BLK_BYTES),
  localparam int AW    = OFF_W + 1,
  localparam int IDX_W = $clog2(REC_BYTES),
  localparam int CNT_W = $clog2(ERASE_LIMIT + 1),
  localparam int TRY_W = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          fl_cmd_valid,
  output logic [2:0]    fl_cmd,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  input  logic          fl_done,
  input  logic          fl_err,
  output logic          fault
);

  localparam logic [2:0] CMD_PROG  = 3'd1;
  localparam logic [2:0] CMD_ERASE = 3'd2;
  localparam logic [2:0] CMD_CLR   = 3'd3;
  localparam logic [2:0] CMD_STAT  = 3'd4;

  typedef enum logic [3:0] {
    S_COLLECT, S_ERASE, S_ERASE_W, S_ESTAT, S_ESTAT_W, S_CLR, S_CLR_W,
    S_PROG, S_PROG_W, S_PSTAT, S_PSTAT_W, S_FAULT
  } st_t;

  st_t              state;
  logic             blk;
  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] idx;
  logic [7:0]       rec_buf [REC_BYTES];
  logic [1:0]       used;
  logic [CNT_W-1:0] ecnt [2];
  logic [TRY_W-1:0] tries;

  wire last_byte = (idx == IDX_W'(REC_BYTES - 1));
  wire need_erase = (off == '0) && used[blk];
  wire at_limit = (ecnt[blk] >= CNT_W'(ERASE_LIMIT));

  assign in_ready = (state == S_COLLECT);
  assign fault    = (state == S_FAULT);
  assign fl_addr  = {blk, off};
  assign fl_wdata = rec_buf[idx];
  assign fl_cmd_valid = (state == S_ERASE) || (state == S_ESTAT) || (state == S_CLR) ||
                        (state == S_PROG)  || (state == S_PSTAT);

  always_comb begin
    case (state)
      S_ERASE:          fl_cmd = CMD_ERASE;
      S_CLR:            fl_cmd = CMD_CLR;
      S_PROG:           fl_cmd = CMD_PROG;
      S_ESTAT, S_PSTAT: fl_cmd = CMD_STAT;
      default:          fl_cmd = 3'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_COLLECT;
      blk     <= 1'b0;
      off     <= '0;
      idx     <= '0;
      used    <= 2'b00;
      ecnt[0] <= '0;
      ecnt[1] <= '0;
      tries   <= '0;
    end else begin
      case (state)
        S_COLLECT: if (in_valid) begin
          rec_buf[idx] <= in_data;
          if (last_byte) begin
            idx   <= '0;
            tries <= '0;
            if (!need_erase)   state <= S_PROG;
            else if (at_limit) state <= S_FAULT;
            else               state <= S_ERASE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_ERASE:   state <= S_ERASE_W;
        S_ERASE_W: if (fl_done) state <= S_ESTAT;
        S_ESTAT:   state <= S_ESTAT_W;
        S_ESTAT_W: if (fl_done) begin
          if (!fl_err) begin
            ecnt[blk] <= ecnt[blk] + 1'b1;
            used[blk] <= 1'b0;
            state     <= S_PROG;
          end else if (tries == TRY_W'(MAX_TRIES - 1)) begin
            state <= S_FAULT;
          end else begin
            tries <= tries + 1'b1;
            state <= S_CLR;
          end
        end
        S_CLR:     state <= S_CLR_W;
        S_CLR_W:   if (fl_done) state <= S_ERASE;
        S_PROG:    state <= S_PROG_W;
        S_PROG_W:  if (fl_done) state <= S_PSTAT;
        S_PSTAT:   state <= S_PSTAT_W;
        S_PSTAT_W: if (fl_done) begin
          if (fl_err) begin
            state <= S_FAULT;
          end else begin
            used[blk] <= 1'b1;
            off       <= off + 1'b1;
            if (off == OFF_W'(BLK_BYTES - 1)) blk <= ~blk;
            if (last_byte) begin
              idx   <= '0;
              state <= S_COLLECT;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_PROG;
            end
          end
        end
        default:   state <= S_FAULT;
      endcase
    end
  end

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd_valid |=> !fl_cmd_valid); // R3
  AST_NO_INTAKE_DURING_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd_valid |-> !in_ready); // R3
  AST_ERASE_UNDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cmd_valid && fl_cmd == CMD_ERASE) |-> (ecnt[blk] < CNT_W'(ERASE_LIMIT))); // R9
  AST_TRIES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    tries < TRY_W'(MAX_TRIES)); // R7
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault); // R11
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!fl_cmd_valid && !in_ready)); // R8

endmodule

// File: tb/rec_log_appender_tb_top.sv
module rec_log_appender_tb_top;
  localparam int BLK = 64;
  localparam int REC = 16;
  localparam int LIM = 2;
  localparam int TRY = 3;
  localparam int AW  = $clog2(BLK) + 1;
  localparam int LAT = 2;

  logic clk = 0, rst_n = 0, in_valid = 0, fl_done = 0, fl_err = 0;
  logic [7:0] in_data = 0;
  logic in_ready, fl_cmd_valid, fault;
  logic [2:0] fl_cmd;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata;

  always #2 clk = ~clk;

  rec_log_appender #(.BLK_BYTES(BLK), .REC_BYTES(REC), .ERASE_LIMIT(LIM), .MAX_TRIES(TRY)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .fl_cmd_valid(fl_cmd_valid), .fl_cmd(fl_cmd), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_done(fl_done), .fl_err(fl_err), .fault(fault));

  int checks = 0, fails = 0, cyc = 0;
  logic [2:0] q_cmd[$];
  int q_addr[$], q_data[$];
  string q_tag[$];
  bit written [2*BLK];

  int mblk, moff, mused[2], mecnt[2], mfail, mprogfail;
  bit mfault;
  int fail_left, prog_fail, pend;
  bit cur_err;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] c, input int a, input int d, input string t);
    q_cmd.push_back(c); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(t);
  endtask

  function automatic int bval(input int r, input int i);
    return (r * 7 + i * 13 + 5) & 255;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    fl_done = 0;
    if (!rst_n) begin
      pend = 0; cur_err = 0;
    end else begin
      if (pend > 0) chk(!in_ready, "R3 ready while busy", in_ready, 0);
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin fl_done = 1; fl_err = cur_err; end
      end
      if (fl_cmd_valid) begin
        pend = LAT;
        if (q_cmd.size() == 0) begin
          chk(0, "R8 unexpected command", fl_cmd, 0);
        end else begin
          logic [2:0] ec; int ea, ed; string et;
          ec = q_cmd.pop_front(); ea = q_addr.pop_front(); ed = q_data.pop_front(); et = q_tag.pop_front();
          chk(fl_cmd == ec, {et, " cmd"}, fl_cmd, ec);
          if (ec == 3'd1 || ec == 3'd2) chk(int'(fl_addr) == ea, {et, " addr"}, fl_addr, ea);
          if (ec == 3'd1) chk(int'(fl_wdata) == ed, {et, " data"}, fl_wdata, ed);
        end
        case (fl_cmd)
          3'd1: begin
            chk(!written[fl_addr], "R6 reprogram", fl_addr, -1);
            written[fl_addr] = 1;
            cur_err = (prog_fail > 0);
            if (prog_fail > 0) prog_fail--;
          end
          3'd2: begin
            cur_err = (fail_left > 0);
            if (fail_left > 0) fail_left--;
            if (!cur_err) for (int k = 0; k < BLK; k++) written[(fl_addr / BLK) * BLK + k] = 0;
          end
          3'd3: cur_err = 0;
          default: ;
        endcase
      end
    end
  end

  task automatic model_record(input int r);
    int t;
    if (mfault) return;
    if (moff == 0 && mused[mblk] != 0) begin
      if (mecnt[mblk] >= LIM) begin mfault = 1; return; end
      t = 0;
      forever begin
        push(3'd2, mblk * BLK, 0, "R5");
        push(3'd4, 0, 0, "R5");
        if (mfail > 0) begin
          mfail--; t++;
          if (t >= TRY) begin mfault = 1; return; end
          push(3'd3, 0, 0, "R7");
        end else begin
          mecnt[mblk]++; mused[mblk] = 0;
          break;
        end
      end
    end
    for (int i = 0; i < REC; i++) begin
      push(3'd1, mblk * BLK + moff, bval(r, i), (moff == 0 && i == 0) ? "R4" : "R2");
      push(3'd4, 0, 0, "R2");
      if (mprogfail > 0) begin mprogfail = 0; mfault = 1; return; end
      moff++; mused[mblk] = 1;
    end
    if (moff == BLK) begin mblk ^= 1; moff = 0; end
  endtask

  task automatic send_record(input int r);
    model_record(r);
    for (int i = 0; i < REC; i++) begin
      for (int w = 0; w < 2000; w++) begin
        @(negedge clk);
        if (in_ready) break;
      end
      if (i == 0) chk(q_cmd.size() > 0 || mfault, "R2 commands queued", 0, 0);
      in_valid = 1; in_data = 8'(bval(r, i));
      @(posedge clk); #1;
      in_valid = 0;
      if (i < REC - 1) chk(!fl_cmd_valid, "R2 no command mid-record", fl_cmd_valid, 0);
    end
    for (int w = 0; w < 3000; w++) begin
      @(negedge clk);
      if (in_ready || fault) break;
    end
    chk(q_cmd.size() == 0, "R2 record commands complete", q_cmd.size(), 0);
    chk(fault == mfault, "R8 fault state", fault, mfault);
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0;
    q_cmd.delete(); q_addr.delete(); q_data.delete(); q_tag.delete();
    for (int k = 0; k < 2 * BLK; k++) written[k] = 0;
    mblk = 0; moff = 0; mused[0] = 0; mused[1] = 0; mecnt[0] = 0; mecnt[1] = 0;
    mfail = 0; mprogfail = 0; mfault = 0; fail_left = 0; prog_fail = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1, "R1 ready after reset", in_ready, 1);
    chk(fault == 0, "R11 fault cleared by reset", fault, 0);
    chk(fl_cmd_valid == 0, "R1 idle command port", fl_cmd_valid, 0);
  endtask

  task automatic watch_fault(input string tag);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk(fault && !in_ready, tag, {fault, in_ready}, 2);
    end
  endtask

  initial begin
    do_reset();
    for (int r = 0; r < 8; r++) send_record(r);
    chk(mecnt[0] == 0 && mecnt[1] == 0, "R4 no erase on first pass", mecnt[0], 0);
    mfail = 2; fail_left = 2;
    for (int r = 8; r < 24; r++) send_record(r);
    chk(mecnt[0] == LIM && mecnt[1] == LIM, "R9 counts at limit", mecnt[0], LIM);
    send_record(24);
    chk(fault == 1, "R9 fault at erase limit", fault, 1);
    watch_fault("R11 fault sticky");

    do_reset();
    for (int r = 0; r < 8; r++) send_record(r);
    mfail = 3; fail_left = 3;
    send_record(8);
    chk(fault == 1, "R8 fault after last attempt", fault, 1);
    watch_fault("R8 silent after fault");

    do_reset();
    mprogfail = 1; prog_fail = 1;
    send_record(40);
    chk(fault == 1, "R10 fault on program error", fault, 1);
    watch_fault("R11 fault holds");

    do_reset();
    send_record(50);
    chk(fault == 0, "R1 clean restart", fault, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule